// File: doc/BRIEF.md
# Bus Yield Arbiter

This block sits beside a processor core and decides when the core lets go of the shared system bus. An alternate master, typically a DMA engine, asserts a request line. Once the core has no bus cycle in flight, the arbiter answers with a grant. The alternate master then claims the bus by asserting an acknowledge line, which it may only do while the bus is quiet. From that point the arbiter drops the grant and holds the core's address, data and control drivers in high impedance. Release of the acknowledge ends the hold and returns the bus to the core.

The request, acknowledge, address-strobe and data-acknowledge pins are active low and can change at any time. Each one passes through a synchronizer of `SYNC_STAGES` flops before the state machine sees it. The core's busy flag is already in the system clock domain and is used directly. If the requester gives up before it claims the bus, the offer is withdrawn and the core keeps the bus. An acknowledge raised by some other master while no offer is out also makes the core float its drivers.

Top module: `bus_yield_arbiter`

## Requirements
- R1: During and right after reset, `bus_grant_n` is 1 (no grant) and `bus_hiz` is 0.
- R2: With request asserted (`bus_req_n`=0), `core_busy`=0, address strobe inactive (`addr_strobe_n`=1) and no acknowledge, `bus_grant_n` goes to 0. A change on any synchronized pin first shows on the outputs after the third rising edge that follows it.
- R3: While `core_busy`=1 or the address strobe is active, no grant is offered. A falling `core_busy` takes effect at the very next rising edge.
- R4: While the grant is out, an acknowledge (`grant_ack_n`=0) arriving with the address strobe and data acknowledge both inactive causes `bus_grant_n` to return to 1 and `bus_hiz` to rise at the same edge.
- R5: An acknowledge seen while the address strobe or data acknowledge (`data_ack_n`=0) is still active is not taken as a claim. The grant stays out and `bus_hiz` stays 0 until both lines are inactive.
- R6: `bus_hiz` stays 1 for as long as the acknowledge is asserted, whatever the request does. It falls once the released acknowledge has passed the synchronizer.
- R7: If the request is withdrawn before any acknowledge, the grant is withdrawn and `bus_hiz` stays 0.
- R8: An acknowledge asserted while no grant is out puts the core's drivers in high impedance (`bus_hiz`=1) without raising a grant.
- R9: `bus_grant_n`=0 and `bus_hiz`=1 never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_n | input | 1 | Bus request from an alternate master, active low, asynchronous |
| grant_ack_n | input | 1 | Bus claim by the alternate master, active low, asynchronous |
| addr_strobe_n | input | 1 | Address strobe seen on the bus, active low |
| data_ack_n | input | 1 | Data transfer acknowledge seen on the bus, active low |
| core_busy | input | 1 | Core has a bus cycle in progress, synchronous |
| bus_grant_n | output | 1 | Bus grant to the alternate master, active low |
| bus_hiz | output | 1 | 1 = core address, data and control drivers in high impedance |

## Verification
A pin change reaches the outputs after exactly three rising edges: two synchronizer flops and the state register. A `core_busy` change acts after one edge. The bench drives inputs on falling edges and compares outputs at the following falling edges. Its reference model replays every pin sample through a two-deep queue, so the model works from the same delayed view the state machine has. The directed checks look one edge before and one edge at the expected change, so a result that comes early or late fails.

// File: rtl/yield_pkg.sv
package yield_pkg;

  typedef enum logic [1:0] {
    ST_OWN   = 2'd0,
    ST_OFFER = 2'd1,
    ST_YIELD = 2'd2
  } arb_state_e;

  localparam int unsigned PIN_COUNT = 4;
  localparam int unsigned PIN_REQ   = 3;
  localparam int unsigned PIN_ACK   = 2;
  localparam int unsigned PIN_STB   = 1;
  localparam int unsigned PIN_DTK   = 0;

  function automatic logic may_offer(input logic req, input logic busy,
                                     input logic strobe);
    return req & ~busy & ~strobe;
  endfunction

  function automatic logic claim_valid(input logic ack, input logic strobe,
                                       input logic dtk);
    return ack & ~strobe & ~dtk;
  endfunction

endpackage

// File: rtl/yield_sync.sv
module yield_sync #(
  parameter int unsigned     WIDTH    = 4,
  parameter int unsigned     STAGES   = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_VAL;
        else        q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_VAL;
        else        q <= g_stage[s-1].q;
      end
    end
  end

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/yield_fsm.sv
module yield_fsm
  import yield_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       ack,
  input  logic       strobe,
  input  logic       dtk,
  input  logic       busy,
  output arb_state_e state,
  output logic       offer_ok,
  output logic       claim_ok
);

  arb_state_e state_nx;

  assign offer_ok = may_offer(req, busy, strobe);
  assign claim_ok = claim_valid(ack, strobe, dtk);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OWN: begin
        if (ack)           state_nx = ST_YIELD;
        else if (offer_ok) state_nx = ST_OFFER;
      end
      ST_OFFER: begin
        if (claim_ok)      state_nx = ST_YIELD;
        else if (!req)     state_nx = ST_OWN;
      end
      ST_YIELD: begin
        if (!ack)          state_nx = ST_OWN;
      end
      default:             state_nx = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OWN;
    else        state <= state_nx;
  end

endmodule

// File: rtl/yield_drive.sv
module yield_drive
  import yield_pkg::*;
(
  input  arb_state_e state,
  output logic       grant_n,
  output logic       hiz
);

  assign grant_n = (state != ST_OFFER);
  assign hiz     = (state == ST_YIELD);

endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter
  import yield_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_n,
  input  logic grant_ack_n,
  input  logic addr_strobe_n,
  input  logic data_ack_n,
  input  logic core_busy,
  output logic bus_grant_n,
  output logic bus_hiz
);

  logic [PIN_COUNT-1:0] pins_raw;
  logic [PIN_COUNT-1:0] pins_sync;
  logic req_s, ack_s, strobe_s, dtk_s;
  logic offer_ok, claim_ok;
  arb_state_e state;

  assign pins_raw[PIN_REQ] = bus_req_n;
  assign pins_raw[PIN_ACK] = grant_ack_n;
  assign pins_raw[PIN_STB] = addr_strobe_n;
  assign pins_raw[PIN_DTK] = data_ack_n;

  yield_sync #(
    .WIDTH   (PIN_COUNT),
    .STAGES  (SYNC_STAGES),
    .IDLE_VAL({PIN_COUNT{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_raw),
    .dout (pins_sync)
  );

  assign req_s    = ~pins_sync[PIN_REQ];
  assign ack_s    = ~pins_sync[PIN_ACK];
  assign strobe_s = ~pins_sync[PIN_STB];
  assign dtk_s    = ~pins_sync[PIN_DTK];

  yield_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_s),
    .ack     (ack_s),
    .strobe  (strobe_s),
    .dtk     (dtk_s),
    .busy    (core_busy),
    .state   (state),
    .offer_ok(offer_ok),
    .claim_ok(claim_ok)
  );

  yield_drive u_drive (
    .state  (state),
    .grant_n(bus_grant_n),
    .hiz    (bus_hiz)
  );

endmodule

// File: rtl/bus_yield_checker.sv
module bus_yield_checker (
  input logic clk,
  input logic rst_n,
  input logic core_busy,
  input logic bus_grant_n,
  input logic bus_hiz,
  input logic req_s,
  input logic ack_s,
  input logic strobe_s,
  input logic dtk_s
);

  // R9
  grant_hiz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_grant_n && bus_hiz));

  // R2
  offer_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant_n && !bus_hiz && req_s && !core_busy && !strobe_s && !ack_s)
    |=> !bus_grant_n);

  // R3
  offer_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant_n && (core_busy || strobe_s)) |=> bus_grant_n);

  // R4
  claim_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant_n && ack_s && !strobe_s && !dtk_s) |=> (bus_grant_n && bus_hiz));

  // R5
  claim_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant_n && req_s && ack_s && (strobe_s || dtk_s))
    |=> (!bus_grant_n && !bus_hiz));

  // R6
  hiz_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hiz && ack_s) |=> bus_hiz);

  // R6
  hiz_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hiz && !ack_s) |=> (!bus_hiz && bus_grant_n));

  // R7
  offer_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant_n && !req_s && !ack_s) |=> (bus_grant_n && !bus_hiz));

  // R8
  foreign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant_n && !bus_hiz && ack_s) |=> (bus_grant_n && bus_hiz));

endmodule

bind bus_yield_arbiter bus_yield_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_busy  (core_busy),
  .bus_grant_n(bus_grant_n),
  .bus_hiz    (bus_hiz),
  .req_s      (req_s),
  .ack_s      (ack_s),
  .strobe_s   (strobe_s),
  .dtk_s      (dtk_s)
);

// File: tb/test_bus_yield_arbiter.sv
module test_bus_yield_arbiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, ack_n = 1'b1, as_n = 1'b1, dtk_n = 1'b1, busy = 1'b0;
  logic grant_n, hiz;

  int    total = 0;
  int    bad = 0;
  string phase = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  bus_yield_arbiter i_bus_yield_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_n    (req_n),
    .grant_ack_n  (ack_n),
    .addr_strobe_n(as_n),
    .data_ack_n   (dtk_n),
    .core_busy    (busy),
    .bus_grant_n  (grant_n),
    .bus_hiz      (hiz)
  );

  // Reference model: 0 = core owns bus, 1 = grant offered, 2 = bus handed over
  int         m_st;
  logic [3:0] seen[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0;
      seen = {4'hF, 4'hF};
    end else begin
      logic [3:0] v;
      bit r, a, s, d;
      v = seen.pop_front();
      r = !v[3]; a = !v[2]; s = !v[1]; d = !v[0];
      if (m_st == 2) begin
        if (!a) m_st = 0;
      end else if (m_st == 1) begin
        if (a && !s && !d) m_st = 2;
        else if (!r)       m_st = 0;
      end else begin
        if (a)                       m_st = 2;
        else if (r && !busy && !s)   m_st = 1;
      end
      seen.push_back({req_n, ack_n, as_n, dtk_n});
    end
  end

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {grant_n,hiz} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(phase, {grant_n, hiz}, {(m_st != 1), (m_st == 2)});
      total++;
      if (!grant_n && hiz) begin
        bad++;
        $display("FAIL R9: {grant_n,hiz} actual=%b expected=not 00/01 combo 01", {grant_n, hiz});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    logic [15:0] lfsr;
    tick(3);
    check("R1", {grant_n, hiz}, 2'b10);
    rst_n = 1'b1;
    tick(1);
    check("R1", {grant_n, hiz}, 2'b10);

    // R2: offer after three edges
    phase = "R2"; req_n = 1'b0;
    tick(2); check("R2", {grant_n, hiz}, 2'b10);
    tick(1); check("R2", {grant_n, hiz}, 2'b00);

    // R4: clean claim
    phase = "R4"; ack_n = 1'b0;
    tick(2); check("R4", {grant_n, hiz}, 2'b00);
    tick(1); check("R4", {grant_n, hiz}, 2'b11);

    // R6: hold while ack, release with ack
    phase = "R6"; req_n = 1'b1;
    tick(6); check("R6", {grant_n, hiz}, 2'b11);
    ack_n = 1'b1;
    tick(2); check("R6", {grant_n, hiz}, 2'b11);
    tick(1); check("R6", {grant_n, hiz}, 2'b10);

    // R3: core busy defers the offer
    phase = "R3"; busy = 1'b1; req_n = 1'b0;
    tick(10); check("R3", {grant_n, hiz}, 2'b10);
    busy = 1'b0;
    tick(1); check("R3", {grant_n, hiz}, 2'b00);

    // R7: request dropped before claim
    phase = "R7"; req_n = 1'b1;
    tick(2); check("R7", {grant_n, hiz}, 2'b00);
    tick(1); check("R7", {grant_n, hiz}, 2'b10);
    tick(2); check("R7", {grant_n, hiz}, 2'b10);

    // R3: active address strobe defers the offer
    phase = "R3"; as_n = 1'b0; req_n = 1'b0;
    tick(8); check("R3", {grant_n, hiz}, 2'b10);
    as_n = 1'b1;
    tick(2); check("R3", {grant_n, hiz}, 2'b10);
    tick(1); check("R3", {grant_n, hiz}, 2'b00);

    // R5: claim while strobe active is not taken
    phase = "R5"; as_n = 1'b0; ack_n = 1'b0;
    tick(8); check("R5", {grant_n, hiz}, 2'b00);
    as_n = 1'b1;
    tick(2); check("R5", {grant_n, hiz}, 2'b00);
    tick(1); check("R5", {grant_n, hiz}, 2'b11);
    ack_n = 1'b1; req_n = 1'b1;
    tick(3); check("R6", {grant_n, hiz}, 2'b10);

    // R5: claim while data acknowledge active is not taken
    phase = "R5"; req_n = 1'b0;
    tick(3); check("R5", {grant_n, hiz}, 2'b00);
    dtk_n = 1'b0; ack_n = 1'b0;
    tick(8); check("R5", {grant_n, hiz}, 2'b00);
    dtk_n = 1'b1;
    tick(3); check("R5", {grant_n, hiz}, 2'b11);
    ack_n = 1'b1; req_n = 1'b1;
    tick(3); check("R6", {grant_n, hiz}, 2'b10);

    // R8: foreign master holds the bus without a grant
    phase = "R8"; ack_n = 1'b0;
    tick(3); check("R8", {grant_n, hiz}, 2'b11);
    req_n = 1'b0;
    tick(4); check("R8", {grant_n, hiz}, 2'b11);
    ack_n = 1'b1;
    tick(3); check("R8", {grant_n, hiz}, 2'b10);
    tick(1); check("R2", {grant_n, hiz}, 2'b00);
    req_n = 1'b1;
    tick(3); check("R7", {grant_n, hiz}, 2'b10);

    // R9: scrambled pins, model compared every cycle
    phase = "R9";
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) req_n = ~req_n;
      if (lfsr[5:3] == 3'd1) ack_n = ~ack_n;
      if (lfsr[8:6] == 3'd2) as_n  = ~as_n;
      if (lfsr[11:9] == 3'd3) dtk_n = ~dtk_n;
      if (lfsr[14:12] == 3'd4) busy = ~busy;
      tick(1);
    end

    done = 1'b1;
    report();
  end

endmodule